// File: doc/BRIEF.md
# Receive Byte Queue with Occupancy and Watermark

This block is the receive-side byte queue of a serial two-wire controller. A bus engine pushes each received byte into a sixteen-entry store. A register bus pops one byte each time software reads the data-receive register. The block reports the number of bytes held as a zero-based occupancy code. It also provides a status byte with full and empty flags.

Software programs a zero-based watermark. The block raises a level interrupt while the stored count equals the watermark plus one. The watermark may be rewritten at any time, including in the middle of a transfer. A typical use is to shrink it to the smaller of sixteen and the number of bytes still expected, minus one. A synchronous flush input empties the queue and keeps the programmed watermark.

Top module: `rxq_watermark_fifo`

## Requirements
- R1: After reset:
  - the queue is empty;
  - `occ_code` is 0 and `wm_level` is 0;
  - `irq` is 0;
  - `status` equals 8'h40.
- R2: Bytes leave in the order they arrived. An accepted pop loads the oldest byte into `rd_data` at the clock edge that accepts it.
- R3: While the queue holds N bytes (N from 1 to 16), `occ_code` equals N-1. While the queue is empty, `occ_code` is 0.
- R4: `status` bit 5 is 1 exactly when 16 bytes are held. Bit 6 is 1 exactly when none are held. All other status bits are 0.
- R5: A push into a full queue with no pop in the same cycle is dropped. Occupancy, contents and read order stay unchanged.
- R6: A pop from an empty queue leaves `rd_data` at its previous value and leaves the queue empty.
- R7: A push and a pop in the same cycle leave the count unchanged when the queue is neither empty nor full. Both are accepted when the queue is full. When the queue is empty, only the push is accepted.
- R8: `irq` is a registered level. In each cycle it equals whether, in the previous cycle, the stored count was exactly the watermark plus one.
- R9: A write to the watermark takes effect at the next clock edge and is read back on `wm_level`. A write in mid-transfer changes `irq` accordingly one cycle later.
- R10: `flush` empties the queue at the next edge. It has priority over a push or pop in the same cycle, and it keeps both the watermark and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous queue clear |
| wr_en | input | 1 | Push strobe from the bus engine |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe, one per data-register read |
| rd_data | output | 8 | Last popped byte |
| wm_we | input | 1 | Watermark write strobe |
| wm_wdata | input | 4 | Zero-based watermark to write |
| wm_level | output | 4 | Current watermark |
| occ_code | output | 4 | Zero-based occupancy |
| status | output | 8 | Bit 5 full, bit 6 empty, others 0 |
| irq | output | 1 | Registered watermark-reached level |

## Verification
On every cycle, the assertions check the following:
- the full and empty flags never both set;
- reserved status bits stay zero;
- a push into a full queue is dropped;
- a pop from an empty queue holds `rd_data`;
- `flush` empties the queue;
- watermark writes land;
- `irq` follows the previous cycle's occupancy-versus-watermark match.

Byte ordering, the exact occupancy value at each fill level, and same-cycle push/pop acceptance at the boundaries need a reference queue. Only the bench's sweeps over every watermark and fill level can show those behaviours.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_W         = 8;
  localparam int STAT_FULL_BIT  = 5;
  localparam int STAT_EMPTY_BIT = 6;

  typedef struct packed {
    logic full;
    logic empty;
  } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_empty, is_full;

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == FULL_CNT);

  // A pop needs data. A push needs room, or a pop freeing a slot in the same cycle.
  assign pop_ok  = pop_req && !is_empty && !flush;
  assign push_ok = push_req && (!is_full || pop_ok) && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) begin
        wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
      end
      if (pop_ok) begin
        rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
  assign count  = cnt_q;
endmodule

// File: rtl/rxq_wm.sv
module rxq_wm #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wm_we,
  input  logic [PTR_W-1:0] wm_wdata,
  input  logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] wm_level,
  output logic             irq
);
  logic [PTR_W-1:0] wm_q, wm_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] target;

  // The watermark is zero-based: a value of k waits for k+1 stored bytes.
  assign target = CNT_W'(wm_q) + CNT_W'(1);

  always_comb begin
    wm_d  = wm_we ? wm_wdata : wm_q;
    irq_d = (count == target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      wm_q  <= wm_d;
      irq_q <= irq_d;
    end
  end

  assign wm_level = wm_q;
  assign irq      = irq_q;
endmodule

// File: rtl/rxq_watermark_fifo.sv
module rxq_watermark_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      rd_en,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      wm_we,
  input  logic [PTR_W-1:0]          wm_wdata,
  output logic [PTR_W-1:0]          wm_level,
  output logic [PTR_W-1:0]          occ_code,
  output logic [rxq_pkg::STAT_W-1:0] status,
  output logic                      irq
);
  import rxq_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push_ok, pop_ok;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, count_m1;
  logic [DATA_W-1:0] head_byte;
  logic [DATA_W-1:0] rd_q, rd_d;
  rxq_flags_t        flags;

  rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_req(wr_en), .pop_req(rd_en),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) i_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(head_byte)
  );

  rxq_wm #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_wm (
    .clk(clk), .rst_n(rst_n), .wm_we(wm_we), .wm_wdata(wm_wdata),
    .count(count), .wm_level(wm_level), .irq(irq)
  );

  // Output byte register: loads on an accepted pop and holds otherwise.
  always_comb begin
    rd_d = pop_ok ? head_byte : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // Zero-based occupancy; an empty queue also reads 0 and is told apart by its flag.
  assign count_m1 = count - CNT_W'(1);
  assign occ_code = (count == '0) ? '0 : count_m1[PTR_W-1:0];

  always_comb begin
    flags.full  = (count == CNT_W'(DEPTH));
    flags.empty = (count == '0);
    status                 = '0;
    status[STAT_FULL_BIT]  = flags.full;
    status[STAT_EMPTY_BIT] = flags.empty;
  end
endmodule

// File: rtl/rxq_fifo_checker.sv
module rxq_fifo_checker #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wm_we,
  input logic [PTR_W-1:0]  wm_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic [PTR_W-1:0]  wm_level,
  input logic [PTR_W-1:0]  occ_code,
  input logic [7:0]        status,
  input logic              irq
);
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[5] && status[6]));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'h9F) == 8'h00);

  a_r3_empty_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> occ_code == '0);

  a_r5_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && wr_en && !rd_en && !flush) |=> (status[5] && $stable(occ_code)));

  a_r6_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && rd_en && !wr_en && !flush) |=> (status[6] && $stable(rd_data)));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (status[6] && $stable(rd_data)));

  a_r9_wm_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wm_we |=> wm_level == $past(wm_wdata));

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == ($past(!status[6]) && ($past(occ_code) == $past(wm_level))));
endmodule

bind rxq_watermark_fifo rxq_fifo_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_rxq_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
  .wm_we(wm_we), .wm_wdata(wm_wdata), .rd_data(rd_data), .wm_level(wm_level),
  .occ_code(occ_code), .status(status), .irq(irq)
);

// File: tb/test_rxq_watermark_fifo.sv
module test_rxq_watermark_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0, wm_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] wm_wdata = '0;
  logic [7:0] rd_data;
  logic [3:0] wm_level, occ_code;
  logic [7:0] status;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [7:0] mq [$];
  logic [7:0] exp_rd = '0;
  int         exp_wm = 0;

  rxq_watermark_fifo i_rxq_watermark_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .wm_we(wm_we), .wm_wdata(wm_wdata),
    .wm_level(wm_level), .occ_code(occ_code), .status(status), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock cycle of stimulus. The model is updated from the requirements. Checks run at the next falling edge.
  task automatic step(input logic w, input logic [7:0] d, input logic r, input logic f);
    bit pop_acc, push_acc;
    int sz;
    sz = mq.size();
    wr_en = w; wr_data = d; rd_en = r; flush = f;
    if (f) begin
      mq.delete();
    end else begin
      pop_acc  = r && (sz > 0);
      push_acc = w && ((sz < DEPTH) || pop_acc);
      if (pop_acc) exp_rd = mq.pop_front();
      if (push_acc) mq.push_back(d);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0;
    sz = mq.size();
    chk("R2 rd_data", int'(rd_data), int'(exp_rd));
    chk("R3 occ_code", int'(occ_code), (sz == 0) ? 0 : sz - 1);
    chk("R4 status", int'(status), (sz == 0) ? 8'h40 : ((sz == DEPTH) ? 8'h20 : 8'h00));
  endtask

  task automatic set_wm(input int v);
    wm_we = 1'b1; wm_wdata = 4'(v);
    @(negedge clk);
    wm_we = 1'b0;
    exp_wm = v;
    chk("R9 wm_level", int'(wm_level), v);
  endtask

  // Idle one cycle so the registered interrupt reflects the current count.
  task automatic chk_irq(input string tag);
    @(negedge clk);
    chk(tag, int'(irq), (mq.size() == exp_wm + 1) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(status), 8'h40);
    chk("R1 occ_code", int'(occ_code), 0);
    chk("R1 wm_level", int'(wm_level), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    // R1: with the reset watermark of 0, a single byte raises the interrupt
    step(1'b1, 8'h5A, 1'b0, 1'b0);
    chk_irq("R1 irq one byte");
    step(1'b0, 8'h00, 1'b1, 1'b0);

    // Sweep of every watermark against every fill level
    for (int wm = 0; wm < DEPTH; wm++) begin
      step(1'b0, 8'h00, 1'b0, 1'b1);
      set_wm(wm);
      chk_irq("R8 irq empty");
      for (int n = 1; n <= DEPTH; n++) begin
        step(1'b1, 8'((wm * 37 + n * 11) & 8'hFF), 1'b0, 1'b0);
        chk_irq("R8 irq fill");
      end
      // R5: a push into a full queue is dropped
      step(1'b1, 8'hEE, 1'b0, 1'b0);
      chk("R5 occ full", int'(occ_code), 15);
      for (int n = 1; n <= DEPTH; n++) begin
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk_irq("R8 irq drain");
      end
      // R6: a pop from an empty queue holds rd_data
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R6 status empty", int'(status), 8'h40);
    end

    // R7: simultaneous push and pop at the boundaries
    set_wm(15);
    step(1'b1, 8'hA1, 1'b1, 1'b0);
    chk("R7 empty both", mq.size(), 1);
    for (int n = 0; n < 7; n++) step(1'b1, 8'(8'h10 + n), 1'b0, 1'b0);
    step(1'b1, 8'hB2, 1'b1, 1'b0);
    chk("R7 mid occ", int'(occ_code), 7);
    for (int n = 0; n < 8; n++) step(1'b1, 8'(8'h30 + n), 1'b0, 1'b0);
    step(1'b1, 8'hC3, 1'b1, 1'b0);
    chk("R7 full both", int'(status), 8'h20);

    // R9: lowering the watermark mid-transfer and then raising it again
    step(1'b0, 8'h00, 1'b0, 1'b1);
    for (int n = 0; n < 5; n++) step(1'b1, 8'(8'h70 + n), 1'b0, 1'b0);
    set_wm(9);
    chk_irq("R9 irq wm9 count5");
    set_wm(4);
    chk_irq("R9 irq wm4 count5");
    chk("R9 irq raised", int'(irq), 1);
    set_wm(6);
    chk_irq("R9 irq wm6 count5");

    // R10: flush wins over push and pop in the same cycle, and keeps the watermark and rd_data
    step(1'b1, 8'h99, 1'b1, 1'b1);
    chk("R10 empty", int'(status), 8'h40);
    chk("R10 wm kept", int'(wm_level), 6);
    chk_irq("R10 irq after flush");
    step(1'b1, 8'h42, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R10 order after flush", int'(rd_data), 8'h42);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule